// File: doc/BRIEF.md
# Strided Two-Dimensional Copy Engine

This engine copies a run of bytes from one region of memory to another. Both regions are made of lines with gaps between them. Each side has its own line length and its own gap, so the read side and the write side start new lines at different points. One byte count covers the whole copy, and gap bytes are never part of that count. Software loads the two base addresses, the byte count and one dimension word for each side, then pulses `start`.

The read side fetches source bytes through a port with one cycle of latency and puts them into a small byte FIFO. The write side takes bytes from that FIFO and stores them one per cycle at the destination addresses. The read side stops issuing reads whenever the FIFO and the read still in flight would overfill it.

When the copy begins, the engine records a flag byte that describes the copy mode. At the end it raises a one-cycle completion pulse. If either line length is zero, the command is rejected with a one-cycle error pulse and no memory is touched.

Top module: `xfer2d_engine`

## Requirements
- R1: After an accepted `start` with nonzero line lengths, exactly `total` bytes are written and exactly `total` bytes are read; gap bytes are not counted.
- R2: Source addresses run from `src_base` one byte at a time. After every `src_dim[15:0]` bytes, the next source address also skips `src_dim[31:16]` bytes.
- R3: Destination addresses follow the same rule using `dst_dim[15:0]` (line) and `dst_dim[31:16]` (gap), independently of the source side.
- R4: The n-th byte written is the n-th byte read, so byte order is kept.
- R5: At an accepted start, `flags` becomes 0x08. Bit 2 is also set when the destination line is shorter than the source line or the destination gap is shorter than the source gap. All other bits stay zero.
- R6: A start with either line length zero makes `err` high for exactly the one cycle after the start. `busy` stays low and no read or write happens.
- R7: `done` is high for one cycle, the cycle after the edge that performed the last write. `busy` falls in the same cycle.
- R8: A `start` received while `busy` is high is ignored: the running copy finishes with its original parameters, and no `err` is produced.
- R9: The number of bytes held in the FIFO plus any read in flight never exceeds DEPTH (8 by default). No read is issued once `total` bytes have been read.
- R10: After reset, `busy`, `done`, `err`, `rd_en` and `wr_en` are low and `flags` is zero.
- R11: A start with `total` zero and valid line lengths performs no reads or writes. It raises `done` the next cycle, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a copy (accepted only when idle) |
| src_base | input | AW | Source start address |
| dst_base | input | AW | Destination start address |
| total | input | CW | Bytes to copy, gaps excluded |
| src_dim | input | 32 | Source gap [31:16], line length [15:0] |
| dst_dim | input | 32 | Destination gap [31:16], line length [15:0] |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a rejected command |
| flags | output | 8 | Copy-mode flag byte latched at start |
| rd_en | output | 1 | Source read request |
| rd_addr | output | AW | Source read address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| wr_en | output | 1 | Destination write strobe |
| wr_addr | output | AW | Destination write address |
| wr_data | output | 8 | Destination write data |

## Verification
A start sampled at edge s appears as `err` after s for a rejected command, as `done` after s for a zero count, and as `busy` and `flags` after s for a normal copy. The first read follows one cycle later. A byte read at edge r enters the FIFO at r+1 and is written at r+2 at the earliest. `done` follows the edge of the last write by exactly one cycle. The bench changes its inputs and samples the outputs on falling edges, so every value it reads has settled since the preceding rising edge. Its memory model logs every read and write with its address, so counts, addresses and data are compared against values the bench computes from the dimension words alone.

// File: rtl/xfer2d_pkg.sv
package xfer2d_pkg;

    localparam int DIM_W = 16;

    typedef struct packed {
        logic [DIM_W-1:0] gap;
        logic [DIM_W-1:0] len;
    } dim_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_t;

    localparam logic [7:0] FLAG_BASE   = 8'h08;
    localparam logic [7:0] FLAG_SHRINK = 8'h04;

    function automatic logic [7:0] mode_flags(input dim_t s, input dim_t d);
        logic shrink;
        shrink = (d.len < s.len) || (d.gap < s.gap);
        return shrink ? (FLAG_BASE | FLAG_SHRINK) : FLAG_BASE;
    endfunction

    function automatic logic dim_bad(input dim_t s, input dim_t d);
        return (s.len == '0) || (d.len == '0);
    endfunction

endpackage

// File: rtl/xfer2d_walker.sv
module xfer2d_walker
    import xfer2d_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  dim_t          dim,
    input  logic          step,
    output logic [AW-1:0] addr
);
    dim_t             dim_q;
    logic [DIM_W-1:0] col_q;
    logic             line_end;

    assign line_end = (col_q == dim_q.len - DIM_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            addr  <= '0;
            col_q <= '0;
            dim_q <= '0;
        end else if (load) begin
            addr  <= base;
            col_q <= '0;
            dim_q <= dim;
        end else if (step) begin
            if (line_end) begin
                addr  <= addr + AW'(1) + AW'(dim_q.gap);
                col_q <= '0;
            end else begin
                addr  <= addr + AW'(1);
                col_q <= col_q + DIM_W'(1);
            end
        end
    end
endmodule

// File: rtl/xfer2d_fifo.sv
module xfer2d_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW = $clog2(DEPTH + 2)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic [W-1:0]    din,
    input  logic            pop,
    output logic [W-1:0]    dout,
    output logic [CNTW-1:0] count,
    output logic            empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;

    assign empty = (count == '0);
    assign dout  = mem[rp];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            case ({push, pop})
                2'b10:   count <= count + CNTW'(1);
                2'b01:   count <= count - CNTW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/xfer2d_engine.sv
module xfer2d_engine
    import xfer2d_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] dst_base,
    input  logic [CW-1:0] total,
    input  logic [31:0]   src_dim,
    input  logic [31:0]   dst_dim,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [7:0]    flags,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);
    localparam int CNTW = $clog2(DEPTH + 2);

    state_t          state;
    logic [CW-1:0]   rd_left, wr_left;
    logic            rd_vld_q;
    logic            done_q, err_q;
    logic [7:0]      flags_q;
    logic            accept, bad, rd_fire, wr_fire;
    logic [CNTW-1:0] fifo_cnt;
    logic            fifo_empty;
    logic [7:0]      fifo_out;
    dim_t            sdim, ddim;

    assign sdim    = dim_t'(src_dim);
    assign ddim    = dim_t'(dst_dim);
    assign accept  = start && (state == ST_IDLE);
    assign bad     = dim_bad(sdim, ddim);
    assign rd_fire = (state == ST_RUN) && (rd_left != '0)
                     && ((fifo_cnt + CNTW'(rd_vld_q)) < CNTW'(DEPTH));
    assign wr_fire = (state == ST_RUN) && !fifo_empty;

    xfer2d_walker #(.AW(AW)) u_src_walk (
        .clk(clk), .rst(rst), .load(accept), .base(src_base),
        .dim(sdim), .step(rd_fire), .addr(rd_addr)
    );

    xfer2d_walker #(.AW(AW)) u_dst_walk (
        .clk(clk), .rst(rst), .load(accept), .base(dst_base),
        .dim(ddim), .step(wr_fire), .addr(wr_addr)
    );

    xfer2d_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst(rst), .push(rd_vld_q), .din(rd_data),
        .pop(wr_fire), .dout(fifo_out), .count(fifo_cnt), .empty(fifo_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            rd_left  <= '0;
            wr_left  <= '0;
            rd_vld_q <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            flags_q  <= '0;
        end else begin
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            rd_vld_q <= rd_fire;
            if (accept) begin
                if (bad) begin
                    err_q <= 1'b1;
                end else if (total == '0) begin
                    done_q  <= 1'b1;
                    flags_q <= mode_flags(sdim, ddim);
                end else begin
                    state   <= ST_RUN;
                    rd_left <= total;
                    wr_left <= total;
                    flags_q <= mode_flags(sdim, ddim);
                end
            end else if (state == ST_RUN) begin
                if (rd_fire) rd_left <= rd_left - CW'(1);
                if (wr_fire) begin
                    wr_left <= wr_left - CW'(1);
                    if (wr_left == CW'(1)) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign busy    = (state == ST_RUN);
    assign done    = done_q;
    assign err     = err_q;
    assign flags   = flags_q;
    assign rd_en   = rd_fire;
    assign wr_en   = wr_fire;
    assign wr_data = fifo_out;
endmodule

// File: rtl/xfer2d_checker.sv
module xfer2d_checker #(
    parameter int AW    = 16,
    parameter int CW    = 32,
    parameter int DEPTH = 8,
    localparam int CNTW = $clog2(DEPTH + 2)
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic [CW-1:0]   total,
    input logic            busy,
    input logic            done,
    input logic            err,
    input logic [7:0]      flags,
    input logic            rd_en,
    input logic            wr_en,
    input logic            push,
    input logic [CNTW-1:0] fifo_cnt
);
    logic [CW-1:0] tot_q, wcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            tot_q <= '0;
            wcnt  <= '0;
        end else if (start && !busy) begin
            tot_q <= total;
            wcnt  <= '0;
        end else if (wr_en) begin
            wcnt <= wcnt + CW'(1);
        end
    end

    a_r1_write_count: assert property (@(posedge clk) disable iff (rst)
        done |-> (wcnt == tot_q));
    a_r5_flag_shape: assert property (@(posedge clk) disable iff (rst)
        busy |-> (flags[3] && ((flags & 8'hF3) == 8'h00)));
    a_r6_err_quiet: assert property (@(posedge clk) disable iff (rst)
        err |-> (!busy && !wr_en && !rd_en && !done));
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> (fifo_cnt < CNTW'(DEPTH)));
    a_r9_bound: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CNTW'(DEPTH));
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!rd_en && !wr_en));
endmodule

bind xfer2d_engine xfer2d_checker #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .start(start), .total(total), .busy(busy),
    .done(done), .err(err), .flags(flags), .rd_en(rd_en), .wr_en(wr_en),
    .push(rd_vld_q), .fifo_cnt(fifo_cnt)
);

// File: tb/xfer2d_engine_test.sv
module xfer2d_engine_test;
    localparam int AW = 16;
    localparam int CW = 32;
    localparam int LOGN = 4096;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] src_base = '0, dst_base = '0;
    logic [CW-1:0] total = '0;
    logic [31:0]   src_dim = '0, dst_dim = '0;
    logic          busy, done, err, rd_en, wr_en;
    logic [7:0]    flags, wr_data;
    logic [7:0]    rd_data = '0;
    logic [AW-1:0] rd_addr, wr_addr;

    int checks = 0;
    int errors = 0;
    int wcnt = 0, rcnt = 0, ecnt = 0;
    logic [AW-1:0] wa [LOGN];
    logic [7:0]    wd [LOGN];

    always #10 clk = ~clk;

    xfer2d_engine #(.AW(AW), .CW(CW), .DEPTH(8)) uut (
        .clk(clk), .rst(rst), .start(start), .src_base(src_base),
        .dst_base(dst_base), .total(total), .src_dim(src_dim),
        .dst_dim(dst_dim), .busy(busy), .done(done), .err(err),
        .flags(flags), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    always @(posedge clk) begin
        if (rd_en) begin
            rd_data <= pat(rd_addr);
            rcnt    <= rcnt + 1;
        end
        if (wr_en && wcnt < LOGN) begin
            wa[wcnt] <= wr_addr;
            wd[wcnt] <= wr_data;
            wcnt     <= wcnt + 1;
        end
        if (err) ecnt <= ecnt + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] place(input logic [AW-1:0] b,
                                            input int k, input int ln, input int gp);
        return b + AW'((k / ln) * (ln + gp) + (k % ln));
    endfunction

    task automatic pulse_start(input logic [AW-1:0] sb, input logic [AW-1:0] db,
                               input int n, input logic [31:0] sd, input logic [31:0] dd);
        src_base = sb; dst_base = db; total = CW'(n); src_dim = sd; dst_dim = dd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (done) begin seen = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic verify_log(input int w0, input int n, input logic [AW-1:0] sb,
                              input logic [AW-1:0] db, input logic [31:0] sd,
                              input logic [31:0] dd);
        int bad = 0;
        for (int k = 0; k < n; k++) begin
            logic [AW-1:0] sa, da;
            sa = place(sb, k, int'(sd[15:0]), int'(sd[31:16]));
            da = place(db, k, int'(dd[15:0]), int'(dd[31:16]));
            if (wa[w0+k] !== da) begin
                bad++;
                if (bad < 4) check(0, "R3", "dest address", wa[w0+k], da);
            end
            if (wd[w0+k] !== pat(sa)) begin
                bad++;
                if (bad < 4) check(0, "R2/R4", "data from source", wd[w0+k], pat(sa));
            end
        end
        check(bad == 0, "R2 R3 R4", "mismatched bytes", bad, 0);
    endtask

    task automatic run_copy(input string name, input logic [AW-1:0] sb,
                            input logic [AW-1:0] db, input int n,
                            input logic [31:0] sd, input logic [31:0] dd,
                            input logic [7:0] exp_flags);
        int w0 = wcnt, r0 = rcnt;
        bit seen;
        pulse_start(sb, db, n, sd, dd);
        check(busy === 1'b1, "R7", {name, " busy after start"}, busy, 1);
        check(flags === exp_flags, "R5", {name, " flags"}, flags, exp_flags);
        wait_done(seen);
        check(seen, "R7", {name, " done seen"}, seen, 1);
        check(busy === 1'b0, "R7", {name, " busy low with done"}, busy, 0);
        check(wcnt - w0 == n, "R1", {name, " write count"}, wcnt - w0, n);
        check(rcnt - r0 == n, "R9", {name, " read count"}, rcnt - r0, n);
        verify_log(w0, n, sb, db, sd, dd);
        @(negedge clk);
        check(done === 1'b0, "R7", {name, " done one cycle"}, done, 0);
    endtask

    task automatic t_reset();
        check(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R10", "status after reset",
              {busy, done, err}, 0);
        check(rd_en === 1'b0 && wr_en === 1'b0, "R10", "strobes after reset", {rd_en, wr_en}, 0);
        check(flags === 8'h00, "R10", "flags after reset", flags, 0);
    endtask

    task automatic t_equal_dims();
        run_copy("equal", 16'h0100, 16'h2000, 24, {16'd4, 16'd8}, {16'd4, 16'd8}, 8'h08);
    endtask

    task automatic t_mixed_dims();
        run_copy("mixed", 16'h0300, 16'h4000, 13, {16'd2, 16'd3}, {16'd1, 16'd5}, 8'h0C);
    endtask

    task automatic t_narrow_dst();
        run_copy("narrow", 16'h0500, 16'h6000, 40, {16'd0, 16'd40}, {16'd3, 16'd7}, 8'h0C);
    endtask

    task automatic t_zero_line();
        int w0 = wcnt, r0 = rcnt;
        pulse_start(16'h0010, 16'h0020, 5, {16'd1, 16'd0}, {16'd1, 16'd4});
        check(err === 1'b1, "R6", "err after bad start", err, 1);
        check(busy === 1'b0, "R6", "busy stays low", busy, 0);
        @(negedge clk);
        check(err === 1'b0, "R6", "err one cycle", err, 0);
        repeat (5) @(negedge clk);
        check(wcnt == w0 && rcnt == r0, "R6", "no memory traffic", wcnt - w0 + rcnt - r0, 0);
        pulse_start(16'h0010, 16'h0020, 5, {16'd1, 16'd4}, {16'd1, 16'd0});
        check(err === 1'b1, "R6", "err for zero dest line", err, 1);
        @(negedge clk);
    endtask

    task automatic t_zero_total();
        int w0 = wcnt, r0 = rcnt;
        pulse_start(16'h0010, 16'h0020, 0, {16'd1, 16'd4}, {16'd1, 16'd4});
        check(done === 1'b1 && busy === 1'b0, "R11", "immediate done", {done, busy}, 2'b10);
        @(negedge clk);
        check(done === 1'b0, "R11", "done one cycle", done, 0);
        repeat (4) @(negedge clk);
        check(wcnt == w0 && rcnt == r0, "R11", "no traffic", wcnt - w0 + rcnt - r0, 0);
    endtask

    task automatic t_start_busy();
        int w0 = wcnt, r0 = rcnt, e0 = ecnt;
        bit seen;
        pulse_start(16'h0700, 16'h8000, 20, {16'd1, 16'd6}, {16'd2, 16'd6});
        repeat (3) @(negedge clk);
        pulse_start(16'h0900, 16'h9000, 50, {16'd0, 16'd0}, {16'd0, 16'd9});
        wait_done(seen);
        check(seen, "R8", "first copy completes", seen, 1);
        check(wcnt - w0 == 20, "R8", "count from first command", wcnt - w0, 20);
        check(rcnt - r0 == 20, "R8", "reads from first command", rcnt - r0, 20);
        verify_log(w0, 20, 16'h0700, 16'h8000, {16'd1, 16'd6}, {16'd2, 16'd6});
        check(ecnt == e0, "R8", "no err from ignored start", ecnt - e0, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_equal_dims();
        t_mixed_dims();
        t_narrow_dst();
        t_zero_line();
        t_zero_total();
        t_start_busy();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule